// File: doc/BRIEF.md
# Two-Wire Bus Bit-Rate Prescaler

This block derives the bit timing for a two-wire bus master from a fast system clock. Three counters are chained. The first counts a programmable half-period of `2*(H+1)` system cycles. The second counts `2^N` wraps of the first, and the third counts `M+1` wraps of the second. When the third counter wraps, the block emits a single-cycle oversampling tick. Each bus clock period is split into ten such ticks, and a slot index from 0 to 9 tells the protocol engine where it stands in the current period.

Software picks the values H, M and N and writes them through two plain write strobes: one for the half-period byte and one for the divider control word. A write only updates a pending copy. The active copy takes the pending value at the next tick, so the slot in progress always runs to its full programmed length. The bus clock rate is therefore `f_sys / (2*(H+1)) / 2^N / (M+1) / 10`. The block has no data stream; every pin is a plain control or status signal.

Top module: `twi_prescaler`

## Requirements
- R1: When synchronous reset is sampled high, the block clears all counters and sets the slot index to 0. Both the pending and the active settings return to H=0x18, M=2, N=0. With these settings the first tick comes 150 cycles after the first cycle with reset low.
- R2: The number of system clock cycles from one tick to the next is exactly `2*(H+1) * 2^N * (M+1)`, computed from the settings active during that slot.
- R3: `os_tick` is high for exactly one clock cycle per slot.
- R4: `slot_idx` changes only on the edge that ends a tick cycle. It steps 0,1,...,9 and then back to 0. `scl_wrap` is high exactly in the tick cycle in which `slot_idx` is 9.
- R5: In the control word `ctl_val`, M is taken from bits 6:3 and N from bits 2:0. H is the full 8-bit `half_val`.
- R6: A write affects only the pending settings. The active settings take the pending value on the edge that ends a tick, so no slot is shortened or stretched by a write made in its middle. A write in the tick cycle itself lands in the pending copy and becomes active one tick later.
- R7: When several writes reach the same field before a tick, the last one wins.
- R8: A reset in the middle of operation discards any pending write, as well as the active settings, and restarts timing as in R1.
- R9: Values outside the useful range still follow the R2 formula. This includes H below 5 and M below 2; for example H=0, M=0, N=0 gives a tick every 2 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| half_wr | input | 1 | Write strobe for the pending half-period value |
| half_val | input | 8 | Half-period value H |
| ctl_wr | input | 1 | Write strobe for the pending divider control word |
| ctl_val | input | 7 | Divider control: M in bits 6:3, N in bits 2:0 |
| os_tick | output | 1 | One-cycle oversampling tick, ten per bus clock period |
| slot_idx | output | 4 | Current slot index (0 to 9) within the bus clock period |
| scl_wrap | output | 1 | High in the tick cycle that ends slot 9 |

## Verification
A counter left at the wrong value, or a wrong terminal count, makes the tick arrive early or late. This is visible at `os_tick` no later than the end of the slot in progress. A wrong slot index shows at `slot_idx` on every cycle, and it shows on `scl_wrap` within ten ticks. If settings were loaded on a write instead of at a tick, the slot containing the write would have the wrong length. If the wrong pending value were loaded, every later slot would be mistimed. A cycle-accurate reference compared on every clock catches any such deviation in the first cycle where the outputs differ.

// File: rtl/twp_pkg.sv
package twp_pkg;
  localparam int THP_W  = 8;
  localparam int MDIV_W = 4;
  localparam int NDIV_W = 3;
  localparam int CTL_W  = MDIV_W + NDIV_W;
  localparam int NMAX_W = (1 << NDIV_W) - 1;
  localparam int PHASES = 10;
  localparam int PH_W   = $clog2(PHASES);

  typedef struct packed {
    logic [THP_W-1:0]  thp;
    logic [MDIV_W-1:0] mdiv;
    logic [NDIV_W-1:0] ndiv;
  } div_cfg_t;

  localparam div_cfg_t CFG_RESET = '{thp: THP_W'(8'h18), mdiv: MDIV_W'(2), ndiv: NDIV_W'(0)};
endpackage

// File: rtl/twp_cfg_stage.sv
module twp_cfg_stage
  import twp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             half_wr,
  input  logic [THP_W-1:0] half_val,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_val,
  input  logic             load,
  output div_cfg_t         active
);
  div_cfg_t pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= CFG_RESET;
      active  <= CFG_RESET;
    end else begin
      if (load) active <= pending;
      if (half_wr) pending.thp <= half_val;
      if (ctl_wr) begin
        pending.mdiv <= ctl_val[NDIV_W +: MDIV_W];
        pending.ndiv <= ctl_val[NDIV_W-1:0];
      end
    end
  end
endmodule

// File: rtl/twp_stage_ctr.sv
module twp_stage_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic [W-1:0] last,
  output logic         wrap
);
  logic [W-1:0] cnt;

  assign wrap = step && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (step) cnt <= wrap ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/twp_phase.sv
module twp_phase #(
  parameter int PHASES = 10,
  localparam int IW = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [IW-1:0] idx,
  output logic          wrap_now
);
  localparam logic [IW-1:0] LAST = IW'(PHASES - 1);

  assign wrap_now = adv && (idx == LAST);

  always_ff @(posedge clk) begin
    if (rst)      idx <= '0;
    else if (adv) idx <= (idx == LAST) ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/twi_prescaler.sv
module twi_prescaler
  import twp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             half_wr,
  input  logic [THP_W-1:0] half_val,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_val,
  output logic             os_tick,
  output logic [PH_W-1:0]  slot_idx,
  output logic             scl_wrap
);
  div_cfg_t          active_cfg;
  logic              half_wrap, pow_wrap, lin_wrap;
  logic [NMAX_W-1:0] pow_last;

  twp_cfg_stage u_cfg (
    .clk(clk), .rst(rst),
    .half_wr(half_wr), .half_val(half_val),
    .ctl_wr(ctl_wr), .ctl_val(ctl_val),
    .load(os_tick), .active(active_cfg)
  );

  // Half-period stage: counts 2*(H+1) cycles.
  twp_stage_ctr #(.W(THP_W + 1)) u_half (
    .clk(clk), .rst(rst), .step(1'b1),
    .last({active_cfg.thp, 1'b1}), .wrap(half_wrap)
  );

  // Power-of-two stage: terminal count is a mask of N ones.
  for (genvar i = 0; i < NMAX_W; i++) begin : g_pow_mask
    assign pow_last[i] = (i < int'(active_cfg.ndiv));
  end

  twp_stage_ctr #(.W(NMAX_W)) u_pow (
    .clk(clk), .rst(rst), .step(half_wrap),
    .last(pow_last), .wrap(pow_wrap)
  );

  // Linear stage: divides by M+1.
  twp_stage_ctr #(.W(MDIV_W)) u_lin (
    .clk(clk), .rst(rst), .step(pow_wrap),
    .last(active_cfg.mdiv), .wrap(lin_wrap)
  );

  assign os_tick = lin_wrap;

  twp_phase #(.PHASES(PHASES)) u_phase (
    .clk(clk), .rst(rst), .adv(lin_wrap),
    .idx(slot_idx), .wrap_now(scl_wrap)
  );
endmodule

// File: rtl/twp_checker.sv
module twp_checker
  import twp_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            os_tick,
  input logic [PH_W-1:0] slot_idx,
  input logic            scl_wrap,
  input div_cfg_t        act
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (slot_idx == '0) && !os_tick && (act == CFG_RESET));

  p_tick_single_r3: assert property (@(posedge clk) disable iff (rst)
    os_tick |=> !os_tick);

  p_slot_range_r4: assert property (@(posedge clk) disable iff (rst)
    slot_idx < PH_W'(PHASES));

  p_slot_step_r4: assert property (@(posedge clk) disable iff (rst)
    os_tick |=> slot_idx == (($past(slot_idx) == PH_W'(PHASES - 1)) ? '0 : $past(slot_idx) + 1'b1));

  p_slot_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !os_tick |=> $stable(slot_idx));

  p_wrap_restart_r4: assert property (@(posedge clk) disable iff (rst)
    scl_wrap |=> slot_idx == '0);

  p_cfg_held_r6: assert property (@(posedge clk) disable iff (rst)
    !os_tick |=> $stable(act));
endmodule

bind twi_prescaler twp_checker u_chk (
  .clk(clk), .rst(rst), .os_tick(os_tick),
  .slot_idx(slot_idx), .scl_wrap(scl_wrap), .act(active_cfg)
);

// File: tb/tb_twi_prescaler.sv
module tb_twi_prescaler;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       half_wr = 1'b0;
  logic [7:0] half_val = 8'h0;
  logic       ctl_wr = 1'b0;
  logic [6:0] ctl_val = 7'h0;
  logic       os_tick;
  logic [3:0] slot_idx;
  logic       scl_wrap;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  twi_prescaler dut (
    .clk(clk), .rst(rst), .half_wr(half_wr), .half_val(half_val),
    .ctl_wr(ctl_wr), .ctl_val(ctl_val),
    .os_tick(os_tick), .slot_idx(slot_idx), .scl_wrap(scl_wrap)
  );

  // Behavioural reference: cycles elapsed in slot, and the period formula.
  int a_h = 24, a_m = 2, a_n = 0;
  int p_h = 24, p_m = 2, p_n = 0;
  int elapsed = 0, m_slot = 0;
  bit model_ok = 0;

  function automatic int period_of(int h, int m, int n);
    return 2 * (h + 1) * (1 << n) * (m + 1);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      a_h = 24; a_m = 2; a_n = 0;
      p_h = 24; p_m = 2; p_n = 0;
      elapsed = 0; m_slot = 0;
    end else begin
      if (elapsed == period_of(a_h, a_m, a_n) - 1) begin
        elapsed = 0;
        m_slot = (m_slot + 1) % 10;
        a_h = p_h; a_m = p_m; a_n = p_n;
      end else begin
        elapsed++;
      end
      if (half_wr) p_h = half_val;
      if (ctl_wr) begin
        p_m = ctl_val[6:3];
        p_n = ctl_val[2:0];
      end
    end
    model_ok = 1;
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_ok) begin
      bit et;
      et = (elapsed == period_of(a_h, a_m, a_n) - 1);
      chk("os_tick", int'(os_tick), int'(et));
      chk("slot_idx", int'(slot_idx), m_slot);
      chk("scl_wrap", int'(scl_wrap), int'(et && m_slot == 9));
    end
  end

  task automatic wr_half(logic [7:0] v);
    half_wr = 1'b1; half_val = v;
    @(negedge clk);
    half_wr = 1'b0;
  endtask

  task automatic wr_ctl(int m, int n);
    ctl_wr = 1'b1; ctl_val = {4'(m), 3'(n)};
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R1: reset state and default 150-cycle slots
    cur_req = "R1 R2 R3 R4";
    idle(3);
    rst = 1'b0;
    chk("R1 slot after reset", int'(slot_idx), 0);
    idle(1600);

    // R9: H=0, M=0, N=0 gives 2-cycle slots
    cur_req = "R9 R5 R6";
    wr_half(8'd0);
    wr_ctl(0, 0);
    idle(400);
    wr_half(8'd3);
    wr_ctl(1, 0);
    idle(300);

    // R2 / R5: H=5, M=2, N=1 -> 72 cycles; then M=1, N=2 -> 96 cycles
    cur_req = "R2 R5";
    wr_half(8'd5);
    wr_ctl(2, 1);
    idle(1000);
    wr_ctl(1, 2);
    idle(1200);
    wr_ctl(9, 0);
    idle(1300);

    // R6: writes scattered mid-slot never alter the slot in progress
    cur_req = "R6";
    for (int i = 0; i < 12; i++) begin
      idle(17 + 7 * i);
      wr_half(8'(3 + (i % 6)));
      if (i % 3 == 0) wr_ctl(i % 4, i % 3);
    end
    idle(600);

    // R6: write in the tick cycle lands one tick later
    cur_req = "R6 tick-cycle";
    wr_half(8'd4);
    wr_ctl(0, 1);
    idle(200);
    do @(negedge clk); while (!os_tick);
    wr_half(8'd9);
    idle(400);

    // R7: last of several writes wins
    cur_req = "R7";
    wr_half(8'd2);
    wr_half(8'd6);
    wr_ctl(3, 0);
    wr_ctl(1, 1);
    idle(600);

    // R8: reset mid-run discards pending write
    cur_req = "R8";
    idle(13);
    wr_half(8'd1);
    wr_ctl(0, 0);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    chk("R8 slot after reset", int'(slot_idx), 0);
    idle(1700);

    finish_run();
  end
endmodule